// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block is one slice of an integer datapath that pulls a bitfield out of an operand or writes one into it. It offers three operations: unsigned extract, signed extract and insert. Each runs on either a 32-bit (narrow) or a 64-bit (wide) operand. The field is described by a start position and a length. Every combination of position and length gives a fixed, defined result, including a length of zero and values at or beyond the operand width. The computation is combinational. A single register stage at the output holds the result on a valid/ready stream.

Operations enter on a valid/ready input and leave on a valid/ready output. An operation transfers at a rising edge when `in_valid` and `in_ready` are both high. Its result is offered on `out_result` with `out_valid` high from the next cycle. The result transfers when `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being emptied in the same cycle. A stalled result therefore stays in place and blocks new input. When the consumer accepts every cycle, one operation can pass each cycle.

Operation codes on `in_op`: 0 is unsigned extract, 1 is signed extract, 2 is insert, 3 is reserved. `in_wide` set to 1 selects 64-bit mode. W below means 32 in narrow mode and 64 in wide mode. P and L are the position and length after the masking in R1.

Top module: `bfu_top`

## Requirements
- R1: In narrow mode only bits 7:0 of `in_pos` and `in_len` count, so a position of 0x104 behaves as 4. In wide mode all 32 bits count, so a position of 0x100 is out of range.
- R2: Unsigned extract with P < W and L < W returns operand bits P through P+L-1 in result bits 0 upward. Result bits from operand positions at or above W are zero, and all higher result bits are zero.
- R3: Unsigned extract with P >= W returns 0. With P < W and L >= W it returns the operand shifted right by P, filling with zeros.
- R4: Signed extract with L > 0 and P < W takes the field of min(L, W-P) bits starting at P. It sign-extends that field from its top bit to W bits. A field that runs past bit W-1 therefore gives the operand shifted arithmetically right by P.
- R5: Signed extract with L = 0 returns 0. With L > 0 and P >= W it returns operand bit W-1 copied into all W result bits.
- R6: Insert with P >= W returns `in_base` unchanged. Otherwise the mask is L ones shifted left by P, or all ones shifted left by P when L >= W. The mask is cut to W bits. The result is `in_base` where the mask is clear, and `in_ins` shifted left by P where it is set.
- R7: In narrow mode only the low 32 bits of `in_base` and `in_ins` are used, and result bits 63:32 are zero.
- R8: The reserved code 3 gives a result of 0.
- R9: `in_ready` equals `!out_valid || out_ready`. An operation accepted at an edge is presented with `out_valid` high after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` keeps its value at every following edge until the result transfers.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 2 | Operation code (0 unsigned extract, 1 signed extract, 2 insert, 3 reserved) |
| in_wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| in_base | input | 64 | Source operand for extract, target operand for insert |
| in_ins | input | 64 | Value written by insert |
| in_pos | input | 32 | Field start position |
| in_len | input | 32 | Field length |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result word |

## Verification
Two events can fall in the same cycle: the held result leaving on the output, and a new operation being loaded in its place. The bench provokes this by driving `in_valid` and `out_ready` high together in a back-to-back phase, and by random patterns on both signals in another phase. Each result is compared in order against a queue of values that bench functions compute bit by bit from the requirements. Nothing is lost or duplicated when the load and the drain coincide, and a stalled result must not change while the consumer holds back.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [1:0] {
    BF_EXTU = 2'd0,
    BF_EXTS = 2'd1,
    BF_INS  = 2'd2,
    BF_RSVD = 2'd3
  } bf_op_e;

endpackage

// File: rtl/bfu_prep.sv
// Reduces position and length to the bits the selected mode honours.
module bfu_prep #(
  parameter int POS_W       = 32,
  parameter int NARROW_KEEP = 8
) (
  input  logic             wide,
  input  logic [POS_W-1:0] pos_raw,
  input  logic [POS_W-1:0] len_raw,
  output logic [POS_W-1:0] pos_eff,
  output logic [POS_W-1:0] len_eff
);
  localparam int PAD = POS_W - NARROW_KEEP;

  always_comb begin
    if (wide) begin
      pos_eff = pos_raw;
      len_eff = len_raw;
    end else begin
      pos_eff = {{PAD{1'b0}}, pos_raw[NARROW_KEEP-1:0]};
      len_eff = {{PAD{1'b0}}, len_raw[NARROW_KEEP-1:0]};
    end
  end
endmodule

// File: rtl/bfu_lane.sv
// One operand width: extract (both kinds) and insert.
module bfu_lane
  import bfu_pkg::*;
#(
  parameter int W     = 64,
  parameter int POS_W = 32
) (
  input  bf_op_e           op,
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     ins,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] len,
  output logic [W-1:0]     res
);
  localparam int SW = $clog2(W);
  localparam logic [POS_W-1:0] W_P = POS_W'(W);
  localparam logic [SW:0]      W_S = (SW+1)'(W);

  logic              pos_oor, len_full, len_zero;
  logic [SW-1:0]     sh;
  logic [SW:0]       room, fld, lsh_w, rsh_w;
  logic [W-1:0]      lomask, imask;
  logic [W-1:0]      u_res, s_res, i_res;
  logic signed [W-1:0] s_left, s_field;

  assign pos_oor  = (pos >= W_P);
  assign len_full = (len >= W_P);
  assign len_zero = (len == '0);
  assign sh       = pos[SW-1:0];

  // bits available from the start position to the top of the operand
  assign room   = W_S - {1'b0, sh};
  assign fld    = (len >= POS_W'(room)) ? room : len[SW:0];
  assign lsh_w  = room - fld;
  assign rsh_w  = W_S - fld;

  assign lomask = len_full ? {W{1'b1}} : ((W'(1) << len[SW-1:0]) - W'(1));
  assign imask  = lomask << sh;

  // unsigned extract
  assign u_res = pos_oor ? '0 : ((base >> sh) & lomask);

  // signed extract: move field to the top, then arithmetic shift down
  assign s_left  = $signed(base << lsh_w[SW-1:0]);
  assign s_field = s_left >>> rsh_w[SW-1:0];

  always_comb begin
    if (len_zero)      s_res = '0;
    else if (pos_oor)  s_res = {W{base[W-1]}};
    else               s_res = $unsigned(s_field);
  end

  // insert
  assign i_res = pos_oor ? base : ((base & ~imask) | (imask & (ins << sh)));

  always_comb begin
    unique case (op)
      BF_EXTU: res = u_res;
      BF_EXTS: res = s_res;
      BF_INS:  res = i_res;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bfu_stage.sv
// Single-entry output register on a valid/ready stream.
module bfu_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int NARROW      = 32,
  parameter int POS_W       = 32,
  parameter int NARROW_KEEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic            in_wide,
  input  logic [XLEN-1:0] in_base,
  input  logic [XLEN-1:0] in_ins,
  input  logic [POS_W-1:0] in_pos,
  input  logic [POS_W-1:0] in_len,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result
);
  bf_op_e            op;
  logic [POS_W-1:0]  pos_eff, len_eff;
  logic [XLEN-1:0]   wide_res, narrow_ext, sel_res;
  logic [NARROW-1:0] narrow_res;

  assign op = bf_op_e'(in_op);

  bfu_prep #(.POS_W(POS_W), .NARROW_KEEP(NARROW_KEEP)) u_prep (
    .wide(in_wide), .pos_raw(in_pos), .len_raw(in_len),
    .pos_eff(pos_eff), .len_eff(len_eff)
  );

  bfu_lane #(.W(XLEN), .POS_W(POS_W)) u_lane_wide (
    .op(op), .base(in_base), .ins(in_ins),
    .pos(pos_eff), .len(len_eff), .res(wide_res)
  );

  bfu_lane #(.W(NARROW), .POS_W(POS_W)) u_lane_narrow (
    .op(op), .base(in_base[NARROW-1:0]), .ins(in_ins[NARROW-1:0]),
    .pos(pos_eff), .len(len_eff), .res(narrow_res)
  );

  generate
    if (NARROW < XLEN) begin : g_pad
      assign narrow_ext = {{(XLEN-NARROW){1'b0}}, narrow_res};
    end else begin : g_nopad
      assign narrow_ext = narrow_res;
    end
  endgenerate

  assign sel_res = in_wide ? wide_res : narrow_ext;

  bfu_stage #(.DW(XLEN)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(sel_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_result)
  );
endmodule

// File: rtl/bfu_top_chk.sv
module bfu_top_chk #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [1:0]      in_op,
  input logic            in_wide,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result
);
  logic cap_narrow, cap_rsvd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_narrow <= 1'b0;
      cap_rsvd   <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_narrow <= !in_wide;
      cap_rsvd   <= (in_op == 2'd3);
    end
  end

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_narrow) |-> ((out_result >> NARROW) == '0));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_rsvd) |-> (out_result == '0));
endmodule

bind bfu_top bfu_top_chk #(.XLEN(XLEN), .NARROW(NARROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_wide(in_wide), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result)
);

// File: tb/bfu_top_test.sv
`timescale 1ns/1ps
module bfu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic        in_wide = 1'b0;
  logic [63:0] in_base = '0, in_ins = '0;
  logic [31:0] in_pos = '0, in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;

  int checks = 0;
  int failures = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic        hold_pending = 1'b0;
  logic [63:0] hold_val = '0;
  string       cur_tag = "";

  always #5 clk = ~clk;

  bfu_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_base(in_base), .in_ins(in_ins),
    .in_pos(in_pos), .in_len(in_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [63:0] model(logic [1:0] op, logic wide, logic [63:0] b,
                                        logic [63:0] ins, logic [31:0] pos, logic [31:0] len);
    longint unsigned w, p, l, le;
    logic [63:0] r;
    w = wide ? 64 : 32;
    p = wide ? longint'(pos) : longint'(pos & 32'hFF);
    l = wide ? longint'(len) : longint'(len & 32'hFF);
    r = '0;
    case (op)
      2'd0: for (int i = 0; i < int'(w); i++)
              if (longint'(i) < l && p + longint'(i) < w) r[i] = b[p + longint'(i)];
      2'd1: begin
        if (l == 0) r = '0;
        else if (p >= w) begin
          for (int i = 0; i < int'(w); i++) r[i] = b[w-1];
        end else begin
          le = (l > w - p) ? w - p : l;
          for (int i = 0; i < int'(w); i++)
            r[i] = (longint'(i) < le) ? b[p + longint'(i)] : b[p + le - 1];
        end
      end
      2'd2: begin
        for (int i = 0; i < int'(w); i++) begin
          if (p < w && longint'(i) >= p && (longint'(i) - p) < l) r[i] = ins[longint'(i) - p];
          else r[i] = b[i];
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string classify(logic [1:0] op, logic wide, logic [31:0] pos, logic [31:0] len);
    longint unsigned w, p, l;
    w = wide ? 64 : 32;
    p = wide ? longint'(pos) : longint'(pos & 32'hFF);
    l = wide ? longint'(len) : longint'(len & 32'hFF);
    case (op)
      2'd0: return (p >= w || l >= w) ? "R3" : "R2";
      2'd1: return (l == 0 || p >= w) ? "R5" : "R4";
      2'd2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe();
    #1;
    // R10: a result stalled at the previous edge must be unchanged
    if (hold_pending) begin
      check("R10 valid", {63'd0, out_valid}, 64'd1);
      check("R10 data", out_result, hold_val);
    end
    // R9: readiness rule
    check("R9 ready", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected result", out_result, 64'hx);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_result, e);
      end
    end
    hold_pending = out_valid && !out_ready;
    hold_val = out_result;
    if (in_valid && in_ready) begin
      exp_q.push_back(model(in_op, in_wide, in_base, in_ins, in_pos, in_len));
      tag_q.push_back(cur_tag == "" ? classify(in_op, in_wide, in_pos, in_len) : cur_tag);
      if (!in_wide) tag_q[tag_q.size()-1] = {tag_q[tag_q.size()-1], " R7"};
    end
  endtask

  task automatic directed(string tag, logic [1:0] op, logic wide, logic [63:0] b,
                          logic [63:0] ins, logic [31:0] pos, logic [31:0] len);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = op; in_wide = wide; in_base = b; in_ins = ins; in_pos = pos; in_len = len;
    cur_tag = tag;
    observe();
    cur_tag = "";
  endtask

  function automatic logic [31:0] pick_field();
    case ($urandom % 5)
      0: return $urandom % 70;
      1: return $urandom % 34;
      2: return $urandom;
      3: return 32'h100 + ($urandom % 40);
      default: return 60 + ($urandom % 8);
    endcase
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20250818);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // directed corner cases
    directed("R2", 2'd0, 1'b0, 64'hFFFF_FFFF_1234_5678, '0, 32'd4, 32'd8);
    directed("R1 narrow mask", 2'd0, 1'b0, 64'hFFFF_FFFF_1234_5678, '0, 32'h104, 32'h108);
    directed("R1 wide full", 2'd0, 1'b1, 64'hFFFF_FFFF_1234_5678, '0, 32'h100, 32'd8);
    directed("R3 pos", 2'd0, 1'b0, 64'h1234_5678, '0, 32'd32, 32'd4);
    directed("R3 len", 2'd0, 1'b0, 64'hAAAA_0000_1234_5678, '0, 32'd8, 32'd40);
    directed("R3 wide len", 2'd0, 1'b1, 64'h8000_0000_0000_0000, '0, 32'd4, 32'd64);
    directed("R5 len0", 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, 32'd3, 32'd0);
    directed("R5 pos wide", 2'd1, 1'b1, 64'h8000_0000_0000_0000, '0, 32'd70, 32'd5);
    directed("R5 pos narrow", 2'd1, 1'b0, 64'h8000_0000, '0, 32'd33, 32'd5);
    directed("R4 narrow", 2'd1, 1'b0, 64'h0000_00F0, '0, 32'd4, 32'd4);
    directed("R4 clamp", 2'd1, 1'b1, 64'h8000_0000_0000_0000, '0, 32'd60, 32'd10);
    directed("R4 clamp narrow", 2'd1, 1'b0, 64'h9000_0000, '0, 32'd28, 32'd200);
    directed("R6 basic", 2'd2, 1'b1, 64'h0, 64'hFF, 32'd8, 32'd4);
    directed("R6 pos", 2'd2, 1'b1, 64'h1234, 64'hFF, 32'd64, 32'd4);
    directed("R6 len", 2'd2, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF, 32'd60, 32'd64);
    directed("R6 narrow cut", 2'd2, 1'b0, 64'h0, 64'hFF, 32'd28, 32'd8);
    directed("R8", 2'd3, 1'b1, 64'hDEAD_BEEF, 64'h1, 32'd0, 32'd8);

    // back-to-back: load and drain in the same cycle
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1;
      in_op = 2'($urandom % 4); in_wide = 1'($urandom % 2);
      in_base = {$urandom, $urandom}; in_ins = {$urandom, $urandom};
      in_pos = pick_field(); in_len = pick_field();
      observe();
    end

    // random valid and ready patterns
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      in_valid = ($urandom % 3) != 0; out_ready = ($urandom % 3) != 0;
      in_op = 2'($urandom % 4); in_wide = 1'($urandom % 2);
      in_base = {$urandom, $urandom}; in_ins = {$urandom, $urandom};
      in_pos = pick_field(); in_len = pick_field();
      observe();
    end

    // drain
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      observe();
    end
    check("R9 drained", 64'(exp_q.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule